// File: doc/BRIEF.md
# CAN Fault Confinement Supervisor

This block keeps the transmit and receive error counters of a CAN node and derives the warning and bus-off states from them. The protocol engine reports what happens on the bus as single-cycle pulses: transmit or receive errors (each with a 3-bit error code), successful transfers in either direction, further dominant error sequences during a long disturbance, and runs of recessive bits. The CPU reaches the block only through writes of the initialisation bit.

When either counter climbs to 255, the node goes bus-off. The block then sets the initialisation bit itself and freezes both counters. Recovery does not start until software clears that bit. From then on, each recessive sequence that is reported is posted as a bit-0 error code on the last-error-code update port. After 128 such sequences both counters return to zero, both flags clear and normal counting resumes. Any change of the warning or bus-off flag raises a one-cycle error-interrupt pulse.

Top module: `can_fault_supervisor`

## Requirements
- R1: After reset both counters are 0, and warn_o, busoff_o, init_o, lec_wr_o and err_irq_o are all 0.
- R2: A tx_err_i pulse adds 1 to the transmit counter. A tx_ok_i pulse subtracts 1, but only if tx_err_i is low in the same cycle. rx_err_i and dom_seq_i each add 1 to the receive counter, so both together add 2. rx_ok_i subtracts 1 only when neither of those is high. All updates are visible one cycle after the input.
- R3: The counters saturate. No counter goes above 255, and a decrement at 0 leaves it at 0.
- R4: warn_o is 1 exactly when either counter is at or above 96. It changes in the same cycle as the counter that caused the change.
- R5: In the cycle a counter reaches 255, busoff_o and init_o both become 1. While bus-off, the error, success and dominant-sequence inputs have no effect on the counters.
- R6: An init_wr_i pulse loads init_wdata_i into init_o one cycle later. In the cycle of bus-off entry the forced 1 takes priority over the write.
- R7: While bus-off with init_o at 1, rec_seq_i pulses produce no code update and do not advance recovery.
- R8: While bus-off with init_o at 0, each rec_seq_i pulse gives one lec_wr_o pulse one cycle later, with lec_o = 5 (bit-0 error).
- R9: The 128th counted recessive sequence clears both counters, busoff_o and warn_o in the same cycle as its code update.
- R10: err_irq_o is a one-cycle pulse, high exactly in the cycles where warn_o or busoff_o has just changed.
- R11: Outside bus-off, a tx_err_i or rx_err_i pulse gives a lec_wr_o pulse one cycle later, with lec_o equal to err_code_i. The codes are 0 none, 1 stuff, 2 form, 3 ack, 4 bit-1, 5 bit-0, 6 CRC and 7 unused. A dom_seq_i pulse on its own posts no code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_err_i | input | 1 | Transmit error event pulse |
| tx_ok_i | input | 1 | Successful transmission pulse |
| rx_err_i | input | 1 | Receive error event pulse |
| rx_ok_i | input | 1 | Successful reception pulse |
| dom_seq_i | input | 1 | Further dominant error sequence during a long disturbance |
| err_code_i | input | 3 | Error type that goes with tx_err_i / rx_err_i |
| rec_seq_i | input | 1 | Recessive-bit sequence observed |
| init_wr_i | input | 1 | CPU write strobe for the initialisation bit |
| init_wdata_i | input | 1 | Value written to the initialisation bit |
| tec_o | output | CW | Transmit error counter |
| rec_o | output | CW | Receive error counter |
| warn_o | output | 1 | Error-warning flag |
| busoff_o | output | 1 | Bus-off flag |
| init_o | output | 1 | Initialisation bit |
| lec_wr_o | output | 1 | Last-error-code update strobe |
| lec_o | output | 3 | Last error code |
| err_irq_o | output | 1 | Error-interrupt event pulse |

## Verification
Every output of this block comes from a register. The counters, the flags, the initialisation bit, the code update and the interrupt pulse are all due exactly one cycle after the edge that samples the stimulus. That includes bus-off entry on the 255th error and bus-off exit on the 128th recessive sequence. The bench drives one stimulus per cycle on the falling edge and pushes the result it predicts for that cycle into a queue. A monitor pops one entry shortly after each rising edge, so every comparison lands on the single cycle in which the result becomes due.

// File: rtl/can_fs_pkg.sv
package can_fs_pkg;
    typedef enum logic [2:0] {
        LEC_NONE  = 3'd0,
        LEC_STUFF = 3'd1,
        LEC_FORM  = 3'd2,
        LEC_ACK   = 3'd3,
        LEC_BIT1  = 3'd4,
        LEC_BIT0  = 3'd5,
        LEC_CRC   = 3'd6,
        LEC_RSVD  = 3'd7
    } lec_e;

    typedef struct packed {
        logic       warn;
        logic       boff;
        logic       init;
        logic       lec_wr;
        logic [2:0] lec;
        logic       irq;
    } sup_state_t;
endpackage

// File: rtl/can_err_cnt.sv
module can_err_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   inc_i,
    input  logic         dec_i,
    input  logic         hold_i,
    input  logic         clear_i,
    output logic [W-1:0] cnt_o,
    output logic [W-1:0] cnt_next_o
);
    localparam logic [W+1:0] TOP = {2'b00, {W{1'b1}}};

    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic [W+1:0] sum;

    always_comb begin
        st_d = st_q;
        sum  = {2'b00, st_q.cnt} + {{W{1'b0}}, inc_i};
        if (clear_i)
            st_d.cnt = '0;
        else if (hold_i)
            st_d.cnt = st_q.cnt;
        else if (inc_i != 2'd0)
            st_d.cnt = (sum > TOP) ? {W{1'b1}} : sum[W-1:0];
        else if (dec_i && st_q.cnt != '0)
            st_d.cnt = st_q.cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o      = st_q.cnt;
    assign cnt_next_o = st_d.cnt;

    // R5
    hold_freezes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i && !clear_i |=> $stable(st_q.cnt));
    // R3
    top_saturates_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt == {W{1'b1}} && inc_i != 2'd0 && !clear_i |=> st_q.cnt == {W{1'b1}});
    // R3
    floor_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt == '0 && inc_i == 2'd0 && !clear_i |=> st_q.cnt == '0);
endmodule

// File: rtl/can_busoff_recov.sv
module can_busoff_recov #(
    parameter int N = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active_i,
    input  logic step_i,
    output logic done_o
);
    localparam int RW = (N > 1) ? $clog2(N) : 1;
    localparam logic [RW-1:0] LAST = RW'(N - 1);

    typedef struct packed {
        logic [RW-1:0] cnt;
    } rc_state_t;

    rc_state_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        done_o = active_i && step_i && (st_q.cnt == LAST);
        if (!active_i || done_o)
            st_d.cnt = '0;
        else if (step_i)
            st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R7
    idle_no_progress_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active_i && !step_i |=> $stable(st_q.cnt));
endmodule

// File: rtl/can_fault_supervisor.sv
module can_fault_supervisor
    import can_fs_pkg::*;
#(
    parameter int CW            = 8,
    parameter int WARN_LEVEL    = 96,
    parameter int RECOVERY_SEQS = 128
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tx_err_i,
    input  logic          tx_ok_i,
    input  logic          rx_err_i,
    input  logic          rx_ok_i,
    input  logic          dom_seq_i,
    input  logic [2:0]    err_code_i,
    input  logic          rec_seq_i,
    input  logic          init_wr_i,
    input  logic          init_wdata_i,
    output logic [CW-1:0] tec_o,
    output logic [CW-1:0] rec_o,
    output logic          warn_o,
    output logic          busoff_o,
    output logic          init_o,
    output logic          lec_wr_o,
    output logic [2:0]    lec_o,
    output logic          err_irq_o
);
    localparam int NCNT = 2;
    localparam logic [CW-1:0] CMAX  = {CW{1'b1}};
    localparam logic [CW-1:0] WLVL  = CW'(WARN_LEVEL);

    sup_state_t s_d, s_q;

    logic [1:0]    inc   [NCNT];
    logic          dec   [NCNT];
    logic [CW-1:0] cnt_q [NCNT];
    logic [CW-1:0] cnt_n [NCNT];
    logic          step, rec_done, hit;

    assign inc[0] = {1'b0, tx_err_i};
    assign dec[0] = tx_ok_i;
    assign inc[1] = {1'b0, rx_err_i} + {1'b0, dom_seq_i};
    assign dec[1] = rx_ok_i;

    for (genvar g = 0; g < NCNT; g++) begin : g_cnt
        can_err_cnt #(.W(CW)) u_cnt (
            .clk        (clk),
            .rst_n      (rst_n),
            .inc_i      (inc[g]),
            .dec_i      (dec[g]),
            .hold_i     (s_q.boff),
            .clear_i    (rec_done),
            .cnt_o      (cnt_q[g]),
            .cnt_next_o (cnt_n[g])
        );
    end

    assign step = s_q.boff && !s_q.init && rec_seq_i;

    can_busoff_recov #(.N(RECOVERY_SEQS)) u_recov (
        .clk      (clk),
        .rst_n    (rst_n),
        .active_i (s_q.boff),
        .step_i   (step),
        .done_o   (rec_done)
    );

    always_comb begin
        s_d        = s_q;
        s_d.lec_wr = 1'b0;
        if (!s_q.boff && (tx_err_i || rx_err_i)) begin
            s_d.lec_wr = 1'b1;
            s_d.lec    = err_code_i;
        end
        if (step) begin
            s_d.lec_wr = 1'b1;
            s_d.lec    = LEC_BIT0;
        end
        hit = !s_q.boff && (cnt_n[0] == CMAX || cnt_n[1] == CMAX);
        if (hit) begin
            s_d.boff = 1'b1;
            s_d.init = 1'b1;
        end else begin
            if (rec_done)  s_d.boff = 1'b0;
            if (init_wr_i) s_d.init = init_wdata_i;
        end
        s_d.warn = (cnt_n[0] >= WLVL) || (cnt_n[1] >= WLVL);
        s_d.irq  = (s_d.warn != s_q.warn) || (s_d.boff != s_q.boff);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign tec_o     = cnt_q[0];
    assign rec_o     = cnt_q[1];
    assign warn_o    = s_q.warn;
    assign busoff_o  = s_q.boff;
    assign init_o    = s_q.init;
    assign lec_wr_o  = s_q.lec_wr;
    assign lec_o     = s_q.lec;
    assign err_irq_o = s_q.irq;

    // R5
    boff_forces_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.boff) |-> s_q.init);
    // R10
    flag_change_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.warn != $past(s_q.warn)) || (s_q.boff != $past(s_q.boff)) |-> s_q.irq);
    // R8
    recov_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.boff && !s_q.init && rec_seq_i |=> s_q.lec_wr && s_q.lec == LEC_BIT0);
    // R7
    locked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.boff && s_q.init |=> !s_q.lec_wr);
    // R9
    exit_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(s_q.boff) |-> cnt_q[0] == '0 && cnt_q[1] == '0 && !s_q.warn);
endmodule

// File: tb/tb_can_fault_supervisor.sv
module tb_can_fault_supervisor;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic tx_err, tx_ok, rx_err, rx_ok, dom_seq, rec_seq, init_wr, init_wd;
    logic [2:0] code;
    logic [7:0] tec, rec;
    logic warn, boff, init, lec_wr, irq;
    logic [2:0] lec;

    can_fault_supervisor dut (
        .clk(clk), .rst_n(rst_n),
        .tx_err_i(tx_err), .tx_ok_i(tx_ok), .rx_err_i(rx_err), .rx_ok_i(rx_ok),
        .dom_seq_i(dom_seq), .err_code_i(code), .rec_seq_i(rec_seq),
        .init_wr_i(init_wr), .init_wdata_i(init_wd),
        .tec_o(tec), .rec_o(rec), .warn_o(warn), .busoff_o(boff), .init_o(init),
        .lec_wr_o(lec_wr), .lec_o(lec), .err_irq_o(irq)
    );

    typedef struct packed {
        logic [7:0] tec;
        logic [7:0] rec;
        logic warn, boff, init, lecwr;
        logic [2:0] lec;
        logic irq;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int checks = 0, errors = 0;
    bit finished = 0;

    int m_tec = 0, m_rec = 0, m_rc = 0;
    bit m_warn = 0, m_boff = 0, m_init = 0;
    logic [2:0] m_lec = 3'd0;

    function automatic exp_t actual();
        exp_t a;
        a.tec = tec; a.rec = rec; a.warn = warn; a.boff = boff; a.init = init;
        a.lecwr = lec_wr; a.lec = lec; a.irq = irq;
        return a;
    endfunction

    task automatic cmp(input exp_t e, input string t);
        exp_t a = actual();
        checks++;
        if (a !== e) begin
            errors++;
            $display("FAIL %s actual tec=%0d rec=%0d w=%b b=%b i=%b lw=%b lec=%0d irq=%b expected tec=%0d rec=%0d w=%b b=%b i=%b lw=%b lec=%0d irq=%b",
                t, a.tec, a.rec, a.warn, a.boff, a.init, a.lecwr, a.lec, a.irq,
                e.tec, e.rec, e.warn, e.boff, e.init, e.lecwr, e.lec, e.irq);
        end
    endtask

    // monitor: one result per driven cycle, sampled after the rising edge
    always begin
        @(posedge clk);
        #2;
        if (exp_q.size() > 0) cmp(exp_q.pop_front(), tag_q.pop_front());
    end

    task automatic drv(input logic txe, txo, rxe, rxo, dm, input logic [2:0] c,
                       input logic rs, iw, iwd, input string t);
        exp_t e;
        bit pw, pb, lw, done;
        int inc;
        @(negedge clk);
        tx_err = txe; tx_ok = txo; rx_err = rxe; rx_ok = rxo; dom_seq = dm;
        code = c; rec_seq = rs; init_wr = iw; init_wd = iwd;
        pw = m_warn; pb = m_boff; lw = 0; done = 0;
        if (!m_boff) begin
            if (txe) m_tec = (m_tec < 255) ? m_tec + 1 : 255;
            else if (txo && m_tec > 0) m_tec--;
            inc = int'(rxe) + int'(dm);
            if (inc > 0) m_rec = (m_rec + inc > 255) ? 255 : m_rec + inc;
            else if (rxo && m_rec > 0) m_rec--;
            if (txe || rxe) begin lw = 1; m_lec = c; end
        end
        if (m_boff && !m_init && rs) begin
            lw = 1; m_lec = 3'd5; m_rc++;
            if (m_rc == 128) done = 1;
        end
        if (done) begin m_tec = 0; m_rec = 0; m_rc = 0; end
        if (!m_boff && (m_tec == 255 || m_rec == 255)) begin
            m_boff = 1; m_init = 1; m_rc = 0;
        end else begin
            if (done) m_boff = 0;
            if (iw) m_init = iwd;
        end
        m_warn = (m_tec >= 96) || (m_rec >= 96);
        e.tec = 8'(m_tec); e.rec = 8'(m_rec); e.warn = m_warn; e.boff = m_boff;
        e.init = m_init; e.lecwr = lw; e.lec = m_lec;
        e.irq = (m_warn != pw) || (m_boff != pb);
        exp_q.push_back(e);
        tag_q.push_back(t);
    endtask

    task automatic idle(input string t);
        drv(0, 0, 0, 0, 0, 3'd0, 0, 0, 0, t);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        tx_err = 0; tx_ok = 0; rx_err = 0; rx_ok = 0; dom_seq = 0;
        code = 0; rec_seq = 0; init_wr = 0; init_wd = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        cmp('0, "R1 reset state");

        // R2 / R11 basic counting and code posting
        drv(1, 0, 0, 0, 0, 3'd1, 0, 0, 0, "R11 tx stuff");
        drv(1, 0, 0, 0, 0, 3'd6, 0, 0, 0, "R11 tx crc");
        drv(1, 1, 0, 0, 0, 3'd4, 0, 0, 0, "R2 tx err wins over ok");
        drv(0, 1, 0, 0, 0, 3'd0, 0, 0, 0, "R2 tx ok decrement");
        drv(0, 0, 1, 0, 1, 3'd2, 0, 0, 0, "R2 rx err plus dom adds two");
        drv(0, 0, 0, 0, 1, 3'd7, 0, 0, 0, "R11 dom alone posts no code");
        drv(0, 0, 1, 1, 0, 3'd3, 0, 0, 0, "R2 rx ok ignored with err");
        for (int i = 0; i < 6; i++) drv(0, 0, 0, 1, 0, 3'd0, 0, 0, 0, "R3 rx floor at zero");
        for (int i = 0; i < 4; i++) drv(0, 1, 0, 0, 0, 3'd0, 0, 0, 0, "R3 tx floor at zero");

        // R4 / R10 warning threshold
        for (int i = 0; i < 96; i++) drv(1, 0, 0, 0, 0, 3'd4, 0, 0, 0, "R4 ramp to warning");
        drv(0, 1, 0, 0, 0, 3'd0, 0, 0, 0, "R10 warning clears with pulse");
        drv(1, 0, 0, 0, 0, 3'd1, 0, 0, 0, "R10 warning sets with pulse");
        idle("R10 pulse lasts one cycle");

        // R6 init write
        drv(0, 0, 0, 0, 0, 3'd0, 0, 1, 1, "R6 init write one");
        drv(0, 0, 0, 0, 0, 3'd0, 0, 1, 0, "R6 init write zero");

        // R5 bus-off entry with a competing write
        for (int i = 0; i < 158; i++) drv(1, 0, 0, 0, 0, 3'd3, 0, 0, 0, "R5 ramp to bus-off");
        drv(1, 0, 0, 0, 0, 3'd3, 0, 1, 0, "R6 entry beats init write");
        drv(1, 0, 1, 0, 1, 3'd2, 0, 0, 0, "R5 errors ignored in bus-off");
        drv(0, 1, 0, 1, 0, 3'd0, 0, 0, 0, "R5 success ignored in bus-off");

        // R7 locked: recessive sequences ignored
        for (int i = 0; i < 5; i++) drv(0, 0, 0, 0, 0, 3'd0, 1, 0, 0, "R7 locked recovery ignored");
        drv(0, 0, 0, 0, 0, 3'd0, 0, 1, 0, "R6 software releases init");

        // R8 / R9 recovery
        for (int i = 0; i < 127; i++) begin
            drv(0, 0, 0, 0, 0, 3'd0, 1, 0, 0, "R8 recovery code");
            if (i == 60) idle("R8 gap between sequences");
        end
        drv(0, 0, 0, 0, 0, 3'd0, 1, 0, 0, "R9 recovery completes");
        drv(0, 0, 0, 0, 0, 3'd0, 1, 0, 0, "R9 no code after exit");
        drv(0, 0, 1, 0, 0, 3'd2, 0, 0, 0, "R9 normal counting resumes");
        idle("R1 idle tail");
        @(negedge clk);
        @(negedge clk);
        finish_run();
    end
endmodule